// File: doc/BRIEF.md
# SMBus Block Data Buffer

This block is the byte store behind the single block-data register of an SMBus host controller. It holds up to 32 bytes. The CPU reaches all of them through one register offset, and a shared index moves by one on every access. In a block read, the bus engine fills the store and loads the byte count it received. Software then rewinds the index and drains the bytes through the port. In a block write, software loads the count and the payload, and the bus engine pops the bytes in order until the index reaches the count.

Reading the host control register rewinds the index as a side effect. An auxiliary control register holds two enables: hardware PEC, and buffer mode. When buffer mode is off, port accesses do not move the index. A build-time parameter removes buffer-mode support. In that build the enable bit can never be set and reads back as zero. The bit-level SMBus signalling is not part of this block. The engine side is a plain byte push/pop interface with a count load.

Top module: `smb_blkbuf`

## Requirements
- R1: After reset, the count register reads 0, the auxiliary register reads 0, `pecEn` and `bufModeEn` are 0, and `busEmpty` is 1.
- R2: With buffer mode on, each CPU write to the port (offset 2) stores the byte at the current index, and each CPU read of the port returns the byte at the current index. Either access then advances the index by one, so bytes read back in the order they were written.
- R3: Any CPU read of the host control register (offset 0) returns 0 and resets the index to entry 0, including in the middle of a transfer.
- R4: The count register (offset 1) reads back the last value written to it. It can be written by the CPU, or by the bus engine through `busCntLoad`/`busCntData`. A bus load is visible on the next CPU read.
- R5: Each `busPush` stores `busPushData` at the current index and advances it, so a later CPU read pass returns the pushed bytes in push order.
- R6: `busEmpty` is 1 exactly when the index has reached the stored count. Each `busPop` while not empty presents the entry at the index on `busPopData` and advances the index. A `busPop` while empty leaves the index unchanged.
- R7: The index saturates at 32 and never wraps. At that point port writes and pushes are dropped, port reads return entry 31, and `busEmpty` is 1 even when the count is above 32.
- R8: In the auxiliary register (offset 3), bit 0 enables PEC and bit 1 enables buffer mode. Both read back and drive `pecEn` and `bufModeEn`. In a build with `SUPPORT_BUF=0`, bit 1 always reads 0.
- R9: With buffer mode off, port reads and writes use the current entry without advancing the index, so a second write overwrites the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 2 | Register offset: 0 control, 1 count, 2 port, 3 auxiliary |
| cpuWr | input | 1 | CPU write strobe |
| cpuRd | input | 1 | CPU read strobe; side effects act at the clock edge |
| cpuWdata | input | 8 | CPU write data |
| cpuRdata | output | 8 | Read data for the addressed register; 0 when no read is active |
| pecEn | output | 1 | PEC enable bit |
| bufModeEn | output | 1 | Buffer-mode enable bit |
| busPush | input | 1 | Engine stores one received byte |
| busPushData | input | 8 | Byte to store |
| busPop | input | 1 | Engine takes one byte to send |
| busPopData | output | 8 | Byte at the current index |
| busEmpty | output | 1 | Index has reached the count, or the end of the store |
| busCntLoad | input | 1 | Engine loads the received byte count |
| busCntData | input | 8 | Count value to load |

## Verification
The bench focuses on where the index sits after each event. It rewinds the index halfway through a pass and expects entry 0 again. A design that ignored the control-register read would return later bytes. It issues a pop against an empty buffer and then proves that the next pop yields the byte that was still waiting. A design that advanced anyway would skip that byte. It overfills the store past 32 and reads past the end. A wrapping index would overwrite entry 0 and return early entries instead of a repeated entry 31. Finally, it turns buffer mode off and writes twice. A design that advanced regardless would leave the first byte in entry 0 instead of the second.

// File: rtl/smb_blkbuf_pkg.sv
package smb_blkbuf_pkg;

  localparam int BYTE_W = 8;
  localparam int AUX_PEC_BIT = 0;
  localparam int AUX_BUF_BIT = 1;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_PORT  = 2'd2,
    REG_AUX   = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              idxClr;
    logic              bufWr;
    logic              idxInc;
    logic [BYTE_W-1:0] wrByte;
  } bufCmd_t;

endpackage

// File: rtl/smb_blkbuf_dp.sv
module smb_blkbuf_dp
  import smb_blkbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufCmd_t           cmd,
  output logic [IW-1:0]     idx,
  output logic              atEnd,
  output logic [BYTE_W-1:0] curByte
);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rdAddr;
  logic [AW-1:0]     wrAddr;

  assign atEnd  = (idx == IW'(DEPTH));
  assign wrAddr = idx[AW-1:0];
  assign rdAddr = atEnd ? AW'(DEPTH - 1) : idx[AW-1:0];
  assign curByte = mem[rdAddr];

  // storage is not reset; contents are defined only after being written
  always_ff @(posedge clk) begin
    if (cmd.bufWr && !atEnd) mem[wrAddr] <= cmd.wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               idx <= '0;
    else if (cmd.idxClr)     idx <= '0;
    else if (cmd.idxInc && !atEnd) idx <= idx + IW'(1);
  end

  p_idx_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    idx <= IW'(DEPTH));

  p_idx_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.idxClr |=> (idx == '0));

  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.idxClr && cmd.idxInc && !atEnd) |=> (idx == $past(idx) + IW'(1)));

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.idxClr && atEnd) |=> atEnd);

endmodule

// File: rtl/smb_blkbuf_ctrl.sv
module smb_blkbuf_ctrl
  import smb_blkbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter bit SUPPORT_BUF = 1'b1,
  localparam int IW = $clog2(DEPTH + 1),
  localparam int CMPW = (IW > BYTE_W) ? IW : BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cpuAddr,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [BYTE_W-1:0] cpuWdata,
  output logic [BYTE_W-1:0] cpuRdata,
  output logic              pecEn,
  output logic              bufModeEn,
  input  logic              busPush,
  input  logic [BYTE_W-1:0] busPushData,
  input  logic              busPop,
  output logic              busEmpty,
  input  logic              busCntLoad,
  input  logic [BYTE_W-1:0] busCntData,
  input  logic [IW-1:0]     idx,
  input  logic              atEnd,
  input  logic [BYTE_W-1:0] curByte,
  output bufCmd_t           cmd
);

  regSel_e           sel;
  logic [BYTE_W-1:0] count;
  logic              auxPec;
  logic              auxBuf;
  logic              portWr;
  logic              portAcc;
  logic              ctrlRd;
  logic              cpuBusy;
  logic              pushOk;
  logic              popOk;
  logic [CMPW-1:0]   idxExt;
  logic [CMPW-1:0]   cntExt;

  assign sel     = regSel_e'(cpuAddr);
  assign portWr  = cpuWr && (sel == REG_PORT);
  assign portAcc = (cpuWr || cpuRd) && (sel == REG_PORT);
  assign ctrlRd  = cpuRd && (sel == REG_CTRL);
  assign cpuBusy = portAcc || ctrlRd;

  assign idxExt   = CMPW'(idx);
  assign cntExt   = CMPW'(count);
  assign busEmpty = atEnd || (idxExt >= cntExt);

  // CPU access to the index has priority over the engine in the same cycle
  assign pushOk = busPush && !cpuBusy;
  assign popOk  = busPop && !busEmpty && !cpuBusy;

  always_comb begin
    cmd        = '0;
    cmd.idxClr = ctrlRd;
    cmd.bufWr  = portWr || pushOk;
    cmd.wrByte = portWr ? cpuWdata : busPushData;
    cmd.idxInc = (portAcc && auxBuf) || pushOk || popOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          count <= '0;
    else if (cpuWr && sel == REG_COUNT) count <= cpuWdata;
    else if (busCntLoad)                count <= busCntData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                        auxPec <= 1'b0;
    else if (cpuWr && sel == REG_AUX) auxPec <= cpuWdata[AUX_PEC_BIT];
  end

  generate
    if (SUPPORT_BUF) begin : g_bufMode
      always_ff @(posedge clk) begin
        if (!rstN)                        auxBuf <= 1'b0;
        else if (cpuWr && sel == REG_AUX) auxBuf <= cpuWdata[AUX_BUF_BIT];
      end
    end else begin : g_noBufMode
      assign auxBuf = 1'b0;
    end
  endgenerate

  assign pecEn     = auxPec;
  assign bufModeEn = auxBuf;

  always_comb begin
    cpuRdata = '0;
    if (cpuRd) begin
      unique case (sel)
        REG_CTRL:  cpuRdata = '0;
        REG_COUNT: cpuRdata = count;
        REG_PORT:  cpuRdata = curByte;
        REG_AUX: begin
          cpuRdata[AUX_PEC_BIT] = auxPec;
          cpuRdata[AUX_BUF_BIT] = auxBuf;
        end
        default:   cpuRdata = '0;
      endcase
    end
  end

  p_count_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busCntLoad && !(cpuWr && sel == REG_COUNT)) |=> (count == $past(busCntData)));

  p_pop_empty_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busPop && busEmpty && !busPush && !cpuBusy) |=> $stable(idx));

  p_port_no_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (portAcc && !auxBuf && !busPush && !busPop && !ctrlRd) |=> $stable(idx));

endmodule

// File: rtl/smb_blkbuf.sv
module smb_blkbuf
  import smb_blkbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter bit SUPPORT_BUF = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  cpuAddr,
  input  logic        cpuWr,
  input  logic        cpuRd,
  input  logic [7:0]  cpuWdata,
  output logic [7:0]  cpuRdata,
  output logic        pecEn,
  output logic        bufModeEn,
  input  logic        busPush,
  input  logic [7:0]  busPushData,
  input  logic        busPop,
  output logic [7:0]  busPopData,
  output logic        busEmpty,
  input  logic        busCntLoad,
  input  logic [7:0]  busCntData
);

  localparam int IW = $clog2(DEPTH + 1);

  bufCmd_t           cmd;
  logic [IW-1:0]     idx;
  logic              atEnd;
  logic [BYTE_W-1:0] curByte;

  assign busPopData = curByte;

  smb_blkbuf_ctrl #(.DEPTH(DEPTH), .SUPPORT_BUF(SUPPORT_BUF)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuAddr(cpuAddr), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .pecEn(pecEn), .bufModeEn(bufModeEn),
    .busPush(busPush), .busPushData(busPushData),
    .busPop(busPop), .busEmpty(busEmpty),
    .busCntLoad(busCntLoad), .busCntData(busCntData),
    .idx(idx), .atEnd(atEnd), .curByte(curByte),
    .cmd(cmd)
  );

  smb_blkbuf_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN),
    .cmd(cmd),
    .idx(idx), .atEnd(atEnd), .curByte(curByte)
  );

endmodule

// File: tb/smb_blkbuf_tb.sv
module smb_blkbuf_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cpuAddr = '0;
  logic       cpuWr = 1'b0;
  logic       cpuRd = 1'b0;
  logic [7:0] cpuWdata = '0;
  logic [7:0] cpuRdata;
  logic       pecEn;
  logic       bufModeEn;
  logic       busPush = 1'b0;
  logic [7:0] busPushData = '0;
  logic       busPop = 1'b0;
  logic [7:0] busPopData;
  logic       busEmpty;
  logic       busCntLoad = 1'b0;
  logic [7:0] busCntData = '0;

  logic [7:0] nbRdata;
  logic       nbPecEn;
  logic       nbBufModeEn;
  logic [7:0] nbPopData;
  logic       nbEmpty;

  int checks = 0;
  int failures = 0;

  logic [7:0] cpuExpQ[$];
  string      cpuReqQ[$];
  logic [7:0] popExpQ[$];
  string      popReqQ[$];

  always #10 clk = ~clk;

  smb_blkbuf u_dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .pecEn(pecEn), .bufModeEn(bufModeEn),
    .busPush(busPush), .busPushData(busPushData), .busPop(busPop),
    .busPopData(busPopData), .busEmpty(busEmpty),
    .busCntLoad(busCntLoad), .busCntData(busCntData)
  );

  smb_blkbuf #(.SUPPORT_BUF(1'b0)) u_noBuf (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuWdata(cpuWdata), .cpuRdata(nbRdata), .pecEn(nbPecEn), .bufModeEn(nbBufModeEn),
    .busPush(busPush), .busPushData(busPushData), .busPop(busPop),
    .busPopData(nbPopData), .busEmpty(nbEmpty),
    .busCntLoad(busCntLoad), .busCntData(busCntData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares results against the scoreboard queues away from the edge
  always @(negedge clk) begin
    if (cpuRd && cpuExpQ.size() > 0) begin
      logic [7:0] e;
      string r;
      e = cpuExpQ.pop_front();
      r = cpuReqQ.pop_front();
      chk(cpuRdata === e, r, cpuRdata, e);
      if (cpuAddr == 2'd3) chk(nbRdata[1] === 1'b0, "R8 no-support bit1", nbRdata, 0);
    end
    if (busPop && popExpQ.size() > 0) begin
      logic [7:0] e;
      string r;
      e = popExpQ.pop_front();
      r = popReqQ.pop_front();
      chk(!busEmpty, {r, " empty"}, busEmpty, 0);
      chk(busPopData === e, r, busPopData, e);
    end
  end

  task automatic cpuWrite(input logic [1:0] a, input logic [7:0] d);
    cpuAddr = a; cpuWdata = d; cpuWr = 1'b1;
    @(posedge clk); #1;
    cpuWr = 1'b0;
  endtask

  task automatic cpuRead(input logic [1:0] a, input logic [7:0] e, input string r);
    cpuExpQ.push_back(e); cpuReqQ.push_back(r);
    cpuAddr = a; cpuRd = 1'b1;
    @(posedge clk); #1;
    cpuRd = 1'b0;
  endtask

  task automatic busPushT(input logic [7:0] d);
    busPushData = d; busPush = 1'b1;
    @(posedge clk); #1;
    busPush = 1'b0;
  endtask

  task automatic busPopT(input logic [7:0] e, input string r);
    popExpQ.push_back(e); popReqQ.push_back(r);
    busPop = 1'b1;
    @(posedge clk); #1;
    busPop = 1'b0;
  endtask

  task automatic runTests();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk(busEmpty === 1'b1, "R1 empty", busEmpty, 1);
    chk(pecEn === 1'b0 && bufModeEn === 1'b0, "R1 aux outs", {pecEn, bufModeEn}, 0);
    cpuRead(2'd1, 8'h00, "R1 count");
    cpuRead(2'd3, 8'h00, "R1 aux");

    // R8 aux bits
    cpuWrite(2'd3, 8'h02);
    chk(bufModeEn === 1'b1 && pecEn === 1'b0, "R8 buf only", {pecEn, bufModeEn}, 1);
    cpuWrite(2'd3, 8'h03);
    chk(pecEn === 1'b1, "R8 pec", pecEn, 1);
    chk(nbBufModeEn === 1'b0 && nbPecEn === 1'b1, "R8 no-support outs",
        {nbPecEn, nbBufModeEn}, 2);
    cpuRead(2'd3, 8'h03, "R8 aux readback");

    // R2 / R4: fill through the port, read back in order
    cpuRead(2'd0, 8'h00, "R3 ctrl read");
    cpuWrite(2'd1, 8'h05);
    cpuRead(2'd1, 8'h05, "R4 cpu count");
    for (int i = 0; i < 6; i++) cpuWrite(2'd2, 8'h10 + 8'(i));
    cpuRead(2'd0, 8'h00, "R3 rewind");
    for (int i = 0; i < 6; i++) cpuRead(2'd2, 8'h10 + 8'(i), "R2 port order");

    // R3 rewind mid-transfer
    cpuRead(2'd0, 8'h00, "R3 rewind");
    cpuRead(2'd2, 8'h10, "R3 first");
    cpuRead(2'd2, 8'h11, "R3 second");
    cpuRead(2'd0, 8'h00, "R3 rewind mid");
    cpuRead(2'd2, 8'h10, "R3 back to entry 0");

    // R6 engine pops up to the count
    cpuRead(2'd0, 8'h00, "R3 rewind");
    chk(busEmpty === 1'b0, "R6 not empty", busEmpty, 0);
    for (int i = 0; i < 5; i++) busPopT(8'h10 + 8'(i), "R6 pop order");
    chk(busEmpty === 1'b1, "R6 empty at count", busEmpty, 1);
    busPop = 1'b1; @(posedge clk); #1; busPop = 1'b0;
    cpuWrite(2'd1, 8'h06);
    chk(busEmpty === 1'b0, "R6 count raised", busEmpty, 0);
    busPopT(8'h15, "R6 empty pop held index");
    chk(busEmpty === 1'b1, "R6 empty again", busEmpty, 1);

    // R5 / R4: engine fills, loads count, CPU drains
    cpuRead(2'd0, 8'h00, "R3 rewind");
    for (int i = 0; i < 4; i++) busPushT(8'hA0 + 8'(i));
    busCntData = 8'h04; busCntLoad = 1'b1;
    @(posedge clk); #1; busCntLoad = 1'b0;
    cpuRead(2'd1, 8'h04, "R4 bus count load");
    cpuRead(2'd0, 8'h00, "R3 rewind");
    for (int i = 0; i < 4; i++) cpuRead(2'd2, 8'hA0 + 8'(i), "R5 push order");

    // R7 saturation at the end of the store
    cpuRead(2'd0, 8'h00, "R3 rewind");
    for (int i = 0; i < 32; i++) cpuWrite(2'd2, 8'(i * 3 + 1));
    cpuWrite(2'd2, 8'hEE);
    busPushT(8'hFF);
    cpuWrite(2'd1, 8'd40);
    chk(busEmpty === 1'b1, "R7 empty at end", busEmpty, 1);
    cpuRead(2'd0, 8'h00, "R3 rewind");
    for (int i = 0; i < 32; i++) cpuRead(2'd2, 8'(i * 3 + 1), "R7 full pass");
    cpuRead(2'd2, 8'h5E, "R7 last entry repeat");
    cpuRead(2'd2, 8'h5E, "R7 last entry repeat");

    // R9 buffer mode off: index does not advance
    cpuWrite(2'd3, 8'h00);
    cpuRead(2'd0, 8'h00, "R3 rewind");
    cpuWrite(2'd2, 8'h77);
    cpuWrite(2'd2, 8'h88);
    cpuRead(2'd2, 8'h88, "R9 overwrite");
    cpuRead(2'd2, 8'h88, "R9 no advance");
    cpuWrite(2'd3, 8'h02);
    cpuRead(2'd0, 8'h00, "R3 rewind");
    cpuRead(2'd2, 8'h88, "R9 entry0");
    cpuRead(2'd2, 8'h04, "R9 entry1 untouched");

    @(posedge clk); #1;
    chk(cpuExpQ.size() == 0 && popExpQ.size() == 0, "scoreboard drained",
        cpuExpQ.size() + popExpQ.size(), 0);
  endtask

  initial begin
    bit timedOut;
    timedOut = 1'b0;
    fork
      runTests();
      begin
        #(20 * 100000);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) chk(1'b0, "watchdog", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule